// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Front End

This block is the bus-facing half of a small byte-wide nonvolatile memory. It watches a two-wire serial bus (a clock line and a bidirectional data line), recognises bus start and stop conditions, and answers only when the first byte of a transfer carries its own seven-bit slave address. A write transfer sets an internal byte pointer and may deliver one data byte. A read transfer streams bytes out from the pointer for as long as the master keeps acknowledging.

The array itself sits outside the block behind a plain memory port with an address, write data, a one-cycle write strobe and an asynchronous read data input. When an accepted write is closed by a stop, the block pulses the strobe and then holds `busy_o` high for a parameterised number of clock cycles, which models the nonvolatile programming time. While busy, the block ignores the bus completely. A pair of boundary inputs defines an inclusive address window in which writes are refused.

Top module: `eeprom_serial_slave`

## Requirements
- R1: A start condition is SDA falling while SCL is high, and a stop condition is SDA rising while SCL is high. Both are taken from two-flop synchronised copies of the lines. A start seen while not busy, including one in the middle of a byte, restarts reception of the address byte.
- R2: The first byte after a start is acknowledged only if its bits [7:1] equal {DEV_ID, DEV_SEL} (7'b1010000 by default). Bit 0 is the direction: 0 means write and 1 means read. On a mismatch, the block acknowledges nothing until the next start.
- R3: Each acknowledge is given by driving SDA low (`sda_oe_o`=1) from the SCL fall after the eighth bit until the fall after the ninth clock. The block changes `sda_oe_o` only while synchronised SCL is low. After reset, `sda_oe_o`, `mem_we_o` and `busy_o` are 0.
- R4: A write transfer is an address byte, a word address byte (its low AW bits are kept) and one data byte, and each of these is acknowledged. Further data bytes get no acknowledge and are discarded. A stop then produces exactly one `mem_we_o` pulse carrying that address and data.
- R5: From the cycle after the write strobe, `busy_o` stays high for exactly WR_CYCLES clocks. During that time no byte is acknowledged and `sda_oe_o` stays 0.
- R6: A read transfer sends bytes MSB first, starting at the pointer. The pointer advances by one after every byte sent and wraps from 2^AW-1 to 0.
- R7: When the master does not acknowledge a read byte, the block stops driving SDA until the next start or stop.
- R8: A data byte whose address a satisfies prot_lo <= a <= prot_hi gets no acknowledge, and the following stop produces neither a strobe nor a busy period. When prot_lo > prot_hi, no address is protected.
- R9: After an acknowledged word address, the pointer holds that address. After a completed write, it holds the write address plus one, modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| prot_lo_i | input | AW | Lowest protected address (inclusive) |
| prot_hi_i | input | AW | Highest protected address (inclusive) |
| mem_addr_o | output | AW | Array address for read or write |
| mem_wdata_o | output | 8 | Byte to be written |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_rdata_i | input | 8 | Array contents at `mem_addr_o` |
| busy_o | output | 1 | Write cycle in progress |

## Verification
The bench sweeps all 128 write-direction address bytes. A comparator that checked too few or too many bits would acknowledge a wrong byte, and one that forgot to go silent would acknowledge the byte that follows a rejected address. It writes every address with protection off, and then again with a window in the middle. A window test off by one at either end shows up as a wrong acknowledge, a stray busy period or a changed array byte. Sequential reads cross the top of the array, so a pointer that saturates or fails to advance returns the wrong byte. A probe sent during the write cycle, a restart halfway through a byte, and a second data byte in one write all catch a block that keeps listening while busy, loses its bit count, or writes more than one byte.

// File: rtl/ees_pkg.sv
package ees_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } ees_state_e;

  // Upper seven bits of the first byte against the configured slave address.
  function automatic logic addr_match(input logic [7:0] rx, input logic [6:0] slave);
    return rx[7:1] == slave;
  endfunction

endpackage

// File: rtl/ees_line_sync.sv
module ees_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [1:0] scl_ff;
  logic [1:0] sda_ff;
  logic       scl_q;
  logic       sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign scl_o      = scl_ff[1];
  assign sda_o      = sda_ff[1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;

endmodule

// File: rtl/ees_wr_timer.sv
module ees_wr_timer #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  output logic busy_o
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remain <= '0;
    else if (kick_i)           remain <= CW'(CYCLES);
    else if (remain != '0)     remain <= remain - CW'(1);
  end

  assign busy_o = remain != '0;

  // R5
  kick_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> busy_o);

endmodule

// File: rtl/eeprom_serial_slave.sv
module eeprom_serial_slave #(
  parameter int         AW        = 4,
  parameter logic [3:0] DEV_ID    = 4'b1010,
  parameter logic [2:0] DEV_SEL   = 3'b000,
  parameter int         WR_CYCLES = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic [AW-1:0] prot_lo_i,
  input  logic [AW-1:0] prot_hi_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  output logic          mem_we_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          busy_o
);
  import ees_pkg::*;

  localparam logic [6:0] SLAVE_ADDR = {DEV_ID, DEV_SEL};
  localparam logic [3:0] BIT_SLOT   = 4'd8;
  localparam logic [3:0] BIT_END    = 4'd9;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return p + AW'(1);
  endfunction

  function automatic logic in_window(input logic [AW-1:0] a,
                                     input logic [AW-1:0] lo,
                                     input logic [AW-1:0] hi);
    return (lo <= hi) && (a >= lo) && (a <= hi);
  endfunction

  // synchronised bus events
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  ees_line_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  ees_state_e    state;
  logic [3:0]    bit_cnt;
  logic [7:0]    shreg;
  logic          oe_q;
  logic [AW-1:0] ptr;
  logic          rd_q;
  logic          mack_q;
  logic          pend_q;
  logic [7:0]    wdata_q;
  logic [AW-1:0] waddr_q;
  logic          we_q;

  // named internal events
  logic halted, rx_bit, slot_open, slot_close, tx_next, mack_smp, dev_hit, wr_ok;
  assign halted     = busy_o | we_q;
  assign rx_bit     = scl_rise && (bit_cnt < BIT_SLOT);
  assign slot_open  = scl_fall && (bit_cnt == BIT_SLOT);
  assign slot_close = scl_fall && (bit_cnt == BIT_END);
  assign tx_next    = scl_fall && (bit_cnt != 4'd0) && (bit_cnt < BIT_SLOT);
  assign mack_smp   = scl_rise && (bit_cnt == BIT_SLOT);
  assign dev_hit    = addr_match(shreg, SLAVE_ADDR);
  assign wr_ok      = !in_window(ptr, prot_lo_i, prot_hi_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      oe_q    <= 1'b0;
      ptr     <= '0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
      pend_q  <= 1'b0;
      wdata_q <= '0;
      waddr_q <= '0;
      we_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (halted) begin
        state   <= ST_IDLE;
        oe_q    <= 1'b0;
        bit_cnt <= '0;
      end else if (start_ev) begin
        state   <= ST_DEV;
        oe_q    <= 1'b0;
        bit_cnt <= '0;
        pend_q  <= 1'b0;
      end else if (stop_ev) begin
        state   <= ST_IDLE;
        oe_q    <= 1'b0;
        bit_cnt <= '0;
        if (pend_q) begin
          we_q   <= 1'b1;
          pend_q <= 1'b0;
          ptr    <= ptr_inc(waddr_q);
        end
      end else begin
        if (scl_rise && (bit_cnt < BIT_END)) bit_cnt <= bit_cnt + 4'd1;
        if (slot_close)                      bit_cnt <= '0;
        if (rx_bit && (state != ST_RDATA))   shreg   <= {shreg[6:0], sda_s};
        case (state)
          ST_DEV: begin
            if (slot_open) begin
              if (dev_hit) begin
                oe_q <= 1'b1;
                rd_q <= shreg[0];
              end else begin
                state <= ST_SKIP;
              end
            end else if (slot_close) begin
              if (rd_q) begin
                state <= ST_RDATA;
                shreg <= mem_rdata_i;
                oe_q  <= ~mem_rdata_i[7];
              end else begin
                state <= ST_WADDR;
                oe_q  <= 1'b0;
              end
            end
          end
          ST_WADDR: begin
            if (slot_open) begin
              oe_q <= 1'b1;
              ptr  <= shreg[AW-1:0];
            end else if (slot_close) begin
              oe_q  <= 1'b0;
              state <= ST_WDATA;
            end
          end
          ST_WDATA: begin
            if (slot_open) begin
              if (wr_ok) begin
                oe_q    <= 1'b1;
                pend_q  <= 1'b1;
                wdata_q <= shreg;
                waddr_q <= ptr;
              end else begin
                state <= ST_SKIP;
              end
            end else if (slot_close) begin
              oe_q  <= 1'b0;
              state <= ST_SKIP;
            end
          end
          ST_RDATA: begin
            if (tx_next) begin
              shreg <= {shreg[6:0], 1'b0};
              oe_q  <= ~shreg[6];
            end else if (slot_open) begin
              oe_q <= 1'b0;
            end else if (mack_smp) begin
              mack_q <= ~sda_s;
              ptr    <= ptr_inc(ptr);
            end else if (slot_close) begin
              if (mack_q) begin
                shreg <= mem_rdata_i;
                oe_q  <= ~mem_rdata_i[7];
              end else begin
                state <= ST_SKIP;
                oe_q  <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  ees_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick_i (we_q),
    .busy_o (busy_o)
  );

  assign sda_oe_o    = oe_q;
  assign mem_we_o    = we_q;
  assign mem_wdata_o = wdata_q;
  assign mem_addr_o  = we_q ? waddr_q : ptr;

  // R3
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_s));

  // R5
  quiet_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_oe_o);

  // R8
  we_unprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> !in_window(mem_addr_o, prot_lo_i, prot_hi_i));

  // R4
  we_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> $past(stop_ev));

  // R4
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o);

endmodule

// File: tb/eeprom_serial_slave_bench.sv
module eeprom_serial_slave_bench;
  localparam int AW    = 4;
  localparam int DEPTH = 16;
  localparam int WRC   = 400;
  localparam int Q     = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scl_m = 1'b1;
  logic          sda_m = 1'b1;
  logic [AW-1:0] lo, hi;
  logic          sda_oe, we, busy;
  logic [AW-1:0] maddr;
  logic [7:0]    wdata, rdata;
  logic [7:0]    mem  [DEPTH];
  logic [7:0]    expv [DEPTH];
  int            errors = 0, checks = 0, we_cnt = 0, busy_cnt = 0;
  bit            done = 1'b0;

  wire sda_bus = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  eeprom_serial_slave #(.AW(AW), .WR_CYCLES(WRC)) u_eeprom_serial_slave (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .prot_lo_i   (lo),
    .prot_hi_i   (hi),
    .mem_addr_o  (maddr),
    .mem_wdata_o (wdata),
    .mem_we_o    (we),
    .mem_rdata_i (rdata),
    .busy_o      (busy)
  );

  assign rdata = mem[maddr];

  always @(negedge clk) begin
    if (we) begin
      mem[maddr] <= wdata;
      we_cnt++;
    end
    if (busy) busy_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = !sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    b = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b = {b[6:0], sda_bus}; tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = give_ack ? 1'b0 : 1'b1;
    tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 5000 && busy; g++) tick(1);
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d,
                          output bit k1, output bit k2, output bit k3);
    bus_start();
    wr_byte(8'hA0, k1);
    wr_byte({4'h0, a}, k2);
    wr_byte(d, k3);
    bus_stop();
  endtask

  initial begin
    bit a1, a2, a3, ack, exp_ack;
    logic [7:0] b, d;
    int w0, b0;
    lo = 4'd15; hi = 4'd0;
    for (int i = 0; i < DEPTH; i++) begin mem[i] = 8'h00; expv[i] = 8'h00; end
    tick(5); rst_n = 1'b1; tick(5);

    // R3: reset state
    chk(!sda_oe && !we && !busy, "R3 reset outputs", {sda_oe, we, busy}, 0);

    // R2: sweep of write-direction address bytes
    for (int dv = 0; dv < 128; dv++) begin
      bus_start();
      wr_byte(8'(dv << 1), ack);
      exp_ack = (dv == 8'h50);
      chk(ack == exp_ack, "R2 address match", ack, exp_ack);
      if (!exp_ack && (dv % 16 == 3)) begin
        wr_byte(8'h00, ack);
        chk(!ack, "R2 silent after mismatch", ack, 0);
      end
      bus_stop();
    end
    bus_start();
    wr_byte(8'hA3, ack);
    chk(!ack, "R2 read-direction mismatch", ack, 0);
    bus_stop();

    // R4, R5: write every address with no protection
    w0 = we_cnt;
    for (int a = 0; a < DEPTH; a++) begin
      d  = 8'(a * 29 + 7);
      b0 = busy_cnt;
      do_write(4'(a), d, a1, a2, a3);
      chk(a1 && a2 && a3, "R4 write acks", {a1, a2, a3}, 7);
      tick(1);
      chk(busy, "R5 busy after stop", busy, 1);
      if (a == 5) begin
        bus_start();
        wr_byte(8'hA0, ack);
        chk(!ack && !sda_oe, "R5 silent while busy", ack, 0);
        bus_stop();
      end
      wait_idle();
      if (a == 0) chk(busy_cnt - b0 == WRC, "R5 busy length", busy_cnt - b0, WRC);
      expv[a] = d;
    end
    chk(we_cnt - w0 == DEPTH, "R4 strobe count", we_cnt - w0, DEPTH);
    for (int a = 0; a < DEPTH; a++)
      chk(mem[a] == expv[a], "R4 array contents", mem[a], expv[a]);

    // R9: pointer wrapped to 0 after the write to the top address
    bus_start();
    wr_byte(8'hA1, ack);
    chk(ack, "R6 read address ack", ack, 1);
    rd_byte(1'b0, b);
    chk(b == expv[0], "R9 pointer after write wraps", b, expv[0]);
    bus_stop();

    // R6, R7: sequential read across the top of the array
    bus_start();
    wr_byte(8'hA0, a1);
    wr_byte(8'd13, a2);
    bus_start();
    wr_byte(8'hA1, a3);
    chk(a1 && a2 && a3, "R9 set pointer then restart", {a1, a2, a3}, 7);
    for (int i = 0; i < 5; i++) begin
      rd_byte(i < 4, b);
      chk(b == expv[(13 + i) % DEPTH], "R6 sequential read", b, expv[(13 + i) % DEPTH]);
    end
    rd_byte(1'b0, b);
    chk(b == 8'hFF, "R7 released after no-ack", b, 8'hFF);
    bus_stop();

    // R8: protected window 4..9
    lo = 4'd4; hi = 4'd9;
    w0 = we_cnt;
    for (int a = 0; a < DEPTH; a++) begin
      d = ~expv[a];
      do_write(4'(a), d, a1, a2, a3);
      exp_ack = !(a >= 4 && a <= 9);
      chk(a1 && a2, "R8 address acks", {a1, a2}, 3);
      chk(a3 == exp_ack, "R8 data ack", a3, exp_ack);
      tick(1);
      chk(busy == exp_ack, "R8 write cycle", busy, exp_ack);
      wait_idle();
      if (exp_ack) expv[a] = d;
    end
    chk(we_cnt - w0 == 10, "R8 strobe count", we_cnt - w0, 10);
    for (int a = 0; a < DEPTH; a++)
      chk(mem[a] == expv[a], "R8 array contents", mem[a], expv[a]);
    lo = 4'd15; hi = 4'd0;

    // R1: restart in the middle of an address byte
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    do_write(4'd2, 8'h3C, a1, a2, a3);
    chk(a1 && a2 && a3, "R1 restart mid-byte", {a1, a2, a3}, 7);
    wait_idle();
    expv[2] = 8'h3C;
    chk(mem[2] == expv[2], "R1 write after restart", mem[2], expv[2]);

    // R4: second data byte refused
    bus_start();
    wr_byte(8'hA0, a1);
    wr_byte(8'd6, a2);
    wr_byte(8'h5A, a3);
    wr_byte(8'hC3, ack);
    chk(a1 && a2 && a3 && !ack, "R4 one byte per write", {a1, a2, a3, ack}, 14);
    bus_stop();
    wait_idle();
    expv[6] = 8'h5A;
    chk(mem[6] == expv[6] && mem[7] == expv[7], "R4 single byte stored", mem[7], expv[7]);

    // R9: pointer is write address plus one
    bus_start();
    wr_byte(8'hA1, ack);
    rd_byte(1'b0, b);
    chk(b == expv[7], "R9 pointer after write", b, expv[7]);
    bus_stop();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule